// File: doc/BRIEF.md
# Target-Time Square-Wave Clock Output

This block turns a free-running system-time value into a square wave whose edges land on exact points of that time scale. Software loads a 64-bit start time and a 64-bit half period, both in system-time units, then switches the block on. When the system time reaches the start time, the output flips. With re-arming enabled, the next target is then pushed out by one half period. For a 1 Hz output the half period is 500,000,000 ns scaled into system-time units, and the start time is set to the next half-second boundary. The edges then fall exactly on seconds and half seconds of the system clock.

The configuration is written through a narrow word-wide write port. One control word enables the output, enables re-arming and enables the edge interrupt. A pin-setup word selects output drive and routes the wave to the pin. The target and half-period words are locked while the output is enabled, so software must disable the block before reprogramming it. If the block is enabled with a target that is already in the past, it flips once. It then advances the target silently until the target is ahead of the system time again.

Top module: `pps_gen`

## Requirements
- R1: After reset, pin_out, pin_oe, pin_native_sel and edge_irq are all 0.
- R2: A write to address 1 sets the pin setup: bit 0 drives pin_oe and bit 1 drives pin_native_sel. Both are visible one clock edge after the write cycle. Address 0 is the control word: bit 0 is output enable, bit 1 is re-arm, bit 2 is interrupt enable.
- R3: While enabled, the wave flips at the clock edge whose sampled sys_time is the first to be greater than or equal to the target.
- R4: With re-arm set, each flip adds the half period to the target, so successive edges fall at target, target + half, target + 2*half, and so on.
- R5: If the block is enabled with a target at least one half period behind sys_time, it flips exactly once. It produces no further edge until sys_time reaches the first target + k*half that lies above sys_time.
- R6: With re-arm clear, the block flips once and then stays still. Disabling and re-enabling arms it again with the target as written.
- R7: edge_irq is a one-cycle pulse in the cycle the wave flips, only when the interrupt enable is set. It never pulses without a flip.
- R8: Writing a control word with output enable 0 forces the wave and pin_out low by the second clock edge after the write cycle, with no interrupt.
- R9: Writes to the target words (addresses 2 and 3) and half-period words (addresses 4 and 5) are ignored while output enable is set.
- R10: pin_out follows the wave only when pin_native_sel is 1. Otherwise it is held 0.
- R11: Target and half period are full-width values written as low word then high word (low word at the lower address). The target advance carries across the word boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_time | input | TIME_W | Current system time |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | ADDR_W | Configuration word address |
| wr_data | input | BUS_W | Configuration write data |
| pin_out | output | 1 | Clock-out pin value |
| pin_oe | output | 1 | Pin driven as output |
| pin_native_sel | output | 1 | Pin routed to the timing function |
| edge_irq | output | 1 | One-cycle pulse per output edge |

## Verification
The bench builds the block with TIME_W = 64, BUS_W = 32 and ADDR_W = 4, and drives sys_time directly, advancing it by one unit per cycle. This lets half periods of ten to a hundred units stand in for a real half second, so several edges, a full catch-up run and one-shot re-arming all fit in short windows. Because the low word is 32 bits, setting sys_time just below 2^32 makes a target advance carry into the high word after a few cycles.

// File: rtl/pps_gen_pkg.sv
package pps_gen_pkg;

    // control word, bit 0 = output enable, bit 1 = re-arm, bit 2 = irq enable
    typedef struct packed {
        logic irq_en;
        logic rearm;
        logic out_en;
    } pps_ctrl_t;

    // pin setup word, bit 0 = drive, bit 1 = route wave to pin
    typedef struct packed {
        logic native;
        logic drive;
    } pps_pin_cfg_t;

    localparam int unsigned ADDR_CTRL     = 0;
    localparam int unsigned ADDR_PIN      = 1;
    localparam int unsigned ADDR_TGT_BASE = 2;

endpackage

// File: rtl/pps_regs.sv
module pps_regs
    import pps_gen_pkg::*;
#(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [BUS_W-1:0]               wr_data,
    output pps_ctrl_t                      ctrl_o,
    output pps_pin_cfg_t                   pin_cfg_o,
    output logic [TIME_W-1:0]              half_o,
    output logic [TIME_W/BUS_W-1:0]        tgt_wr_o,
    output logic [BUS_W-1:0]               tgt_wdata_o
);

    localparam int unsigned NWORDS    = TIME_W / BUS_W;
    localparam int unsigned HALF_BASE = ADDR_TGT_BASE + NWORDS;

    typedef struct packed {
        pps_ctrl_t          ctrl;
        pps_pin_cfg_t       pin;
        logic [TIME_W-1:0]  half;
    } regs_t;

    regs_t st_d, st_q;
    logic  locked;

    assign locked = st_q.ctrl.out_en;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_CTRL))
                st_d.ctrl = pps_ctrl_t'(wr_data[$bits(pps_ctrl_t)-1:0]);
            if (wr_addr == ADDR_W'(ADDR_PIN))
                st_d.pin = pps_pin_cfg_t'(wr_data[$bits(pps_pin_cfg_t)-1:0]);
            if (!locked) begin
                for (int k = 0; k < NWORDS; k++) begin
                    if (wr_addr == ADDR_W'(HALF_BASE + k))
                        st_d.half[k*BUS_W +: BUS_W] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // target words live in the edge engine; only strobes go out from here
    for (genvar g = 0; g < NWORDS; g++) begin : g_tgt_strobe
        assign tgt_wr_o[g] = wr_en && !locked &&
                             (wr_addr == ADDR_W'(ADDR_TGT_BASE + g));
    end

    assign tgt_wdata_o = wr_data;
    assign ctrl_o      = st_q.ctrl;
    assign pin_cfg_o   = st_q.pin;
    assign half_o      = st_q.half;

endmodule

// File: rtl/pps_edge_engine.sv
module pps_edge_engine
    import pps_gen_pkg::*;
#(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned BUS_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TIME_W-1:0]        sys_time,
    input  pps_ctrl_t                ctrl,
    input  logic [TIME_W-1:0]        half,
    input  logic [TIME_W/BUS_W-1:0]  tgt_wr,
    input  logic [BUS_W-1:0]         tgt_wdata,
    output logic                     wave_o,
    output logic                     irq_o,
    output logic [TIME_W-1:0]        tgt_o
);

    localparam int unsigned NWORDS = TIME_W / BUS_W;

    typedef struct packed {
        logic [TIME_W-1:0] tgt;
        logic              wave;
        logic              irq;
        logic              catchup;
        logic              armed;
    } eng_t;

    localparam eng_t ENG_RESET = '{tgt: '0, wave: 1'b0, irq: 1'b0,
                                   catchup: 1'b0, armed: 1'b1};

    eng_t              st_d, st_q;
    logic              hit;
    logic              behind;
    logic [TIME_W-1:0] nxt_tgt;

    assign nxt_tgt = st_q.tgt + half;
    assign hit     = (sys_time >= st_q.tgt);
    assign behind  = (nxt_tgt <= sys_time);

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!ctrl.out_en) begin
            st_d.wave    = 1'b0;
            st_d.catchup = 1'b0;
            st_d.armed   = 1'b1;
            for (int k = 0; k < NWORDS; k++) begin
                if (tgt_wr[k])
                    st_d.tgt[k*BUS_W +: BUS_W] = tgt_wdata;
            end
        end else if (st_q.armed && hit) begin
            if (st_q.catchup) begin
                // silent advance: target still behind the clock
                st_d.tgt     = nxt_tgt;
                st_d.catchup = behind;
            end else begin
                st_d.wave = ~st_q.wave;
                st_d.irq  = ctrl.irq_en;
                if (ctrl.rearm) begin
                    st_d.tgt     = nxt_tgt;
                    st_d.catchup = behind;
                end else begin
                    st_d.armed = 1'b0;
                end
            end
        end else begin
            st_d.catchup = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ENG_RESET;
        else        st_q <= st_d;
    end

    assign wave_o = st_q.wave;
    assign irq_o  = st_q.irq;
    assign tgt_o  = st_q.tgt;

endmodule

// File: rtl/pps_pin_mux.sv
module pps_pin_mux
    import pps_gen_pkg::*;
(
    input  logic         wave,
    input  pps_pin_cfg_t pin_cfg,
    output logic         pin_out,
    output logic         pin_oe,
    output logic         pin_native_sel
);

    always_comb begin
        pin_oe         = pin_cfg.drive;
        pin_native_sel = pin_cfg.native;
        pin_out        = pin_cfg.native ? wave : 1'b0;
    end

endmodule

// File: rtl/pps_gen.sv
module pps_gen
    import pps_gen_pkg::*;
#(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] sys_time,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              pin_native_sel,
    output logic              edge_irq
);

    localparam int unsigned NWORDS = TIME_W / BUS_W;

    pps_ctrl_t          ctrl_q;
    pps_pin_cfg_t       pin_cfg_q;
    logic [TIME_W-1:0]  half_q;
    logic [TIME_W-1:0]  tgt_q;
    logic [NWORDS-1:0]  tgt_wr;
    logic [BUS_W-1:0]   tgt_wdata;
    logic               wave_q;

    pps_regs #(.TIME_W(TIME_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ctrl_o      (ctrl_q),
        .pin_cfg_o   (pin_cfg_q),
        .half_o      (half_q),
        .tgt_wr_o    (tgt_wr),
        .tgt_wdata_o (tgt_wdata)
    );

    pps_edge_engine #(.TIME_W(TIME_W), .BUS_W(BUS_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_time  (sys_time),
        .ctrl      (ctrl_q),
        .half      (half_q),
        .tgt_wr    (tgt_wr),
        .tgt_wdata (tgt_wdata),
        .wave_o    (wave_q),
        .irq_o     (edge_irq),
        .tgt_o     (tgt_q)
    );

    pps_pin_mux u_pin (
        .wave           (wave_q),
        .pin_cfg        (pin_cfg_q),
        .pin_out        (pin_out),
        .pin_oe         (pin_oe),
        .pin_native_sel (pin_native_sel)
    );

endmodule

// File: rtl/pps_gen_chk.sv
module pps_gen_chk #(
    parameter int unsigned TIME_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [TIME_W-1:0] sys_time,
    input logic [TIME_W-1:0] tgt,
    input logic [TIME_W-1:0] half,
    input logic              wave,
    input logic              edge_irq
);

    assert_flip_on_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (wave != $past(wave))) |-> ($past(sys_time) >= $past(tgt)));

    assert_irq_with_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_irq |-> (wave != $past(wave)));

    assert_off_is_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !wave);

    assert_target_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> ((tgt == $past(tgt)) || (tgt == $past(tgt) + $past(half))));

endmodule

bind pps_gen pps_gen_chk #(.TIME_W(TIME_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctrl_q.out_en),
    .sys_time (sys_time),
    .tgt      (tgt_q),
    .half     (half_q),
    .wave     (wave_q),
    .edge_irq (edge_irq)
);

// File: tb/pps_gen_tb_top.sv
module pps_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_time = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pin_out, pin_oe, pin_native_sel, edge_irq;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    logic last_pin = 1'b0;

    always #10 clk = ~clk;

    pps_gen #(.TIME_W(64), .BUS_W(32), .ADDR_W(4)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .sys_time       (sys_time),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .pin_out        (pin_out),
        .pin_oe         (pin_oe),
        .pin_native_sel (pin_native_sel),
        .edge_irq       (edge_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input logic [63:0] t0, input logic [63:0] tgt, input logic [63:0] half);
        wr(4'd0, 32'h0);
        sys_time = t0;
        wr(4'd2, tgt[31:0]);
        wr(4'd3, tgt[63:32]);
        wr(4'd4, half[31:0]);
        wr(4'd5, half[63:32]);
    endtask

    task automatic step(output bit tog, output bit irq, output logic [63:0] tu);
        @(negedge clk);
        tog = (pin_out != last_pin);
        last_pin = pin_out;
        irq = edge_irq;
        tu = sys_time;
        sys_time = sys_time + 64'd1;
    endtask

    task automatic observe(input int ncyc, input logic [63:0] e0, input logic [63:0] e1,
                           input int nexp, input bit irq_exp, input string req);
        int seen = 0;
        int irqs = 0;
        int stray = 0;
        logic [63:0] t0 = '0;
        logic [63:0] t1 = '0;
        bit tog, irq;
        logic [63:0] tu;
        for (int i = 0; i < ncyc; i++) begin
            step(tog, irq, tu);
            if (tog) begin
                if (seen == 0) t0 = tu;
                if (seen == 1) t1 = tu;
                seen++;
            end
            if (irq) irqs++;
            if (irq && !tog) stray++;
        end
        chk(seen == nexp, {req, " edge count"}, 64'(seen), 64'(nexp));
        if (nexp >= 1) chk(t0 == e0, {req, " first edge time"}, t0, e0);
        if (nexp >= 2) chk(t1 == e1, {req, " second edge time"}, t1, e1);
        chk(irqs == (irq_exp ? seen : 0), {req, " R7 irq count"}, 64'(irqs), 64'(irq_exp ? seen : 0));
        chk(stray == 0, {req, " R7 irq without edge"}, 64'(stray), 64'd0);
    endtask

    task automatic t_reset;
        chk(pin_out == 1'b0, "R1 pin_out", 64'(pin_out), 64'd0);
        chk(pin_oe == 1'b0, "R1 pin_oe", 64'(pin_oe), 64'd0);
        chk(pin_native_sel == 1'b0, "R1 pin_native_sel", 64'(pin_native_sel), 64'd0);
        chk(edge_irq == 1'b0, "R1 edge_irq", 64'(edge_irq), 64'd0);
    endtask

    task automatic t_pin_cfg;
        wr(4'd1, 32'h1);
        chk(pin_oe == 1'b1, "R2 drive bit", 64'(pin_oe), 64'd1);
        chk(pin_native_sel == 1'b0, "R2 native bit clear", 64'(pin_native_sel), 64'd0);
        wr(4'd1, 32'h3);
        chk(pin_native_sel == 1'b1, "R2 native bit set", 64'(pin_native_sel), 64'd1);
    endtask

    task automatic t_periodic_and_disable;
        bit tog, irq;
        logic [63:0] tu;
        setup(64'd1000, 64'd1010, 64'd20);
        wr(4'd0, 32'h7);
        // R3 R4: edges at 1010, 1030, 1050 in samples 1000..1059
        observe(60, 64'd1010, 64'd1030, 3, 1'b1, "R3 R4 periodic");
        chk(pin_out == 1'b1, "R4 level after three edges", 64'(pin_out), 64'd1);
        // R8: disable forces low without irq
        wr(4'd0, 32'h0);
        step(tog, irq, tu);
        chk(pin_out == 1'b0, "R8 pin low after disable", 64'(pin_out), 64'd0);
        chk(irq == 1'b0, "R8 no irq on disable", 64'(irq), 64'd0);
    endtask

    task automatic t_locked;
        setup(64'd1990, 64'd2000, 64'd50);
        wr(4'd0, 32'h3);
        wr(4'd2, 32'h0);
        wr(4'd4, 32'h1);
        observe(70, 64'd2000, 64'd2050, 2, 1'b0, "R9 writes ignored while enabled");
    endtask

    task automatic t_catchup;
        setup(64'd1000, 64'd0, 64'd100);
        wr(4'd0, 32'h3);
        observe(110, 64'd1000, 64'd1100, 2, 1'b0, "R5 catch-up");
    endtask

    task automatic t_oneshot;
        bit tog, irq;
        logic [63:0] tu;
        setup(64'd3000, 64'd3005, 64'd10);
        wr(4'd0, 32'h1);
        observe(60, 64'd3005, 64'd0, 1, 1'b0, "R6 single edge");
        wr(4'd0, 32'h0);
        step(tog, irq, tu);
        chk(pin_out == 1'b0, "R8 low before rearm", 64'(pin_out), 64'd0);
        sys_time = 64'd3090;
        wr(4'd2, 32'd3100);
        wr(4'd0, 32'h1);
        observe(30, 64'd3100, 64'd0, 1, 1'b0, "R6 rearmed by re-enable");
    endtask

    task automatic t_native_off;
        bit tog, irq;
        logic [63:0] tu;
        int high = 0;
        setup(64'd4000, 64'd4010, 64'd10);
        wr(4'd1, 32'h1);
        wr(4'd0, 32'h3);
        for (int i = 0; i < 50; i++) begin
            step(tog, irq, tu);
            if (pin_out) high++;
        end
        chk(high == 0, "R10 pin held low when not routed", 64'(high), 64'd0);
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h3);
        step(tog, irq, tu);
    endtask

    task automatic t_wide;
        setup(64'hFFFF_FFF0, 64'hFFFF_FFF8, 64'h10);
        wr(4'd0, 32'h7);
        observe(32, 64'hFFFF_FFF8, 64'h1_0000_0008, 2, 1'b1, "R11 carry into high word");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pin_cfg();
        t_periodic_and_disable();
        t_locked();
        t_catchup();
        t_oneshot();
        t_native_off();
        t_wide();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule